// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

The block turns a parallel word into a serial bit stream. Its input holding register samples the parallel inputs when a capture strobe arrives. The shift register behind it gets its contents in one of two ways. In load mode it copies the holding register. In shift mode it clocks in a serial bit on each shift strobe. The last stage of the shift register drives the single serial output.

Both strobes arrive from outside the clock domain. Each one passes through its own two-flop synchroniser, and only its rising edge acts: it becomes a one-cycle enable. An asynchronous active-low clear empties the shift register and leaves the holding register alone. A separate power-on reset clears everything. Several of these blocks can be chained by feeding one block's serial output into the next block's serial input.

Top module: `latched_piso`

## Requirements
- R1: A rising edge on `cap_strobe` copies `par_in` into the holding register on the third `clk` rising edge after the strobe is first sampled high. This happens in either mode. `par_in` bit 0 is stage 0 and bit WIDTH-1 is the last stage.
- R2: While `shift_mode` is 0 (load), the shift register takes the holding register's value on every `clk` edge. In this mode `ser_in` and `shift_strobe` have no effect.
- R3: While `shift_mode` is 1, a detected `shift_strobe` edge moves `ser_in` into stage 0, and each stage i takes the old value of stage i-1. The edge takes effect on the third `clk` edge after the strobe is first sampled high.
- R4: `ser_out` always equals the last stage, WIDTH-1, of the shift register.
- R5: `sr_clr_n` low clears every shift register stage at once, without waiting for a clock edge. It does not change the holding register.
- R6: In load mode, a capture edge brings the new parallel word into the shift register in the same cycle that the holding register takes it.
- R7: If both strobe edges are detected in the same cycle with `shift_mode` 1, the holding register captures and the shift register shifts, both on that edge.
- R8: With `shift_mode` 1 and no detected edge on either strobe, both registers keep their contents.
- R9: `por_n` low clears the holding register, the shift register and both synchronisers.
- R10: A strobe held high for many cycles acts only once. A further action needs the strobe to go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears all state |
| sr_clr_n | input | 1 | Asynchronous active-low clear of the shift register only |
| cap_strobe | input | 1 | Holding-register capture strobe (asynchronous) |
| shift_strobe | input | 1 | Shift strobe (asynchronous) |
| shift_mode | input | 1 | 1 = serial shift, 0 = parallel load from holding register |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data from the last stage |

## Verification
A strobe that is first sampled high at clock edge n acts at edge n+2. The holding register or the shift register changes there, and `ser_out` shows the new value after that edge. A change of `shift_mode` reaches the register at the very next edge. `sr_clr_n` acts at once. The bench's reference model keeps the strobe samples from past edges in a queue and derives each edge's action from them. It compares `ser_out` on every falling edge, half a period after the edge that could have changed it. After an asynchronous clear it also compares one time unit after the clear goes low. The holding register has no output of its own, so its contents are streamed out through load mode followed by shifting.

// File: rtl/latched_piso_pkg.sv
package latched_piso_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } sr_mode_e;

    localparam int STROBE_COUNT = 2;
    localparam int STB_CAP      = 0;
    localparam int STB_SHIFT    = 1;

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], strobe_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/hold_register.sv
module hold_register #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] next_o,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = cap_en ? data_i : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign next_o = hold_d;
    assign q_o    = hold_q;
endmodule

// File: rtl/shift_stage_chain.sv
module shift_stage_chain
    import latched_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sr_mode_e         mode,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] load_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] stages_o
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (mode == MODE_LOAD)
            sr_d = load_i;
        else if (shift_en)
            sr_d = {sr_q[WIDTH-2:0], ser_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign stages_o = sr_q;
endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import latched_piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sr_clr_n,
    input  logic             cap_strobe,
    input  logic             shift_strobe,
    input  logic             shift_mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out
);
    localparam int MSB = WIDTH - 1;

    logic [STROBE_COUNT-1:0] strobes;
    logic [STROBE_COUNT-1:0] pulses;
    logic                    ld_pulse;
    logic                    sh_pulse;
    logic [WIDTH-1:0]        lat_next;
    logic [WIDTH-1:0]        lat_q;
    logic [WIDTH-1:0]        sr_q;
    logic                    sr_rst_n;
    sr_mode_e                mode;

    assign strobes[STB_CAP]   = cap_strobe;
    assign strobes[STB_SHIFT] = shift_strobe;

    for (genvar g = 0; g < STROBE_COUNT; g++) begin : g_sync
        strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (por_n),
            .strobe_i (strobes[g]),
            .pulse_o  (pulses[g])
        );
    end

    assign ld_pulse = pulses[STB_CAP];
    assign sh_pulse = pulses[STB_SHIFT];
    assign sr_rst_n = por_n & sr_clr_n;
    assign mode     = shift_mode ? MODE_SHIFT : MODE_LOAD;

    hold_register #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst_n  (por_n),
        .cap_en (ld_pulse),
        .data_i (par_in),
        .next_o (lat_next),
        .q_o    (lat_q)
    );

    shift_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst_n    (sr_rst_n),
        .mode     (mode),
        .shift_en (sh_pulse),
        .load_i   (lat_next),
        .ser_i    (ser_in),
        .stages_o (sr_q)
    );

    assign ser_out = sr_q[MSB];
endmodule

// File: rtl/latched_piso_chk.sv
module latched_piso_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             sr_clr_n,
    input logic             shift_mode,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_in,
    input logic             ser_out,
    input logic             ld_pulse,
    input logic             sh_pulse,
    input logic [WIDTH-1:0] lat_q,
    input logic [WIDTH-1:0] sr_q
);
    // R1
    capture_takes_par_chk: assert property (@(posedge clk) disable iff (!por_n)
        ld_pulse |=> lat_q == $past(par_in));

    // R2
    load_mode_follows_latch_chk: assert property (@(posedge clk) disable iff (!por_n || !sr_clr_n)
        !shift_mode |=> sr_q == lat_q);

    // R3
    shift_moves_stages_chk: assert property (@(posedge clk) disable iff (!por_n || !sr_clr_n)
        (shift_mode && sh_pulse) |=> sr_q == {$past(sr_q[WIDTH-2:0]), $past(ser_in)});

    // R4
    out_is_last_stage_chk: assert property (@(posedge clk) disable iff (!por_n)
        ser_out == sr_q[WIDTH-1]);

    // R5
    clear_empties_sr_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sr_clr_n |-> sr_q == '0);

    // R8
    idle_holds_sr_chk: assert property (@(posedge clk) disable iff (!por_n || !sr_clr_n)
        (shift_mode && !sh_pulse) |=> $stable(sr_q));

    // R8
    no_capture_holds_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ld_pulse |=> $stable(lat_q));

    // R10
    single_cap_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        ld_pulse |=> !ld_pulse);

    // R10
    single_shift_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        sh_pulse |=> !sh_pulse);
endmodule

bind latched_piso latched_piso_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .sr_clr_n   (sr_clr_n),
    .shift_mode (shift_mode),
    .par_in     (par_in),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .ld_pulse   (ld_pulse),
    .sh_pulse   (sh_pulse),
    .lat_q      (lat_q),
    .sr_q       (sr_q)
);

// File: tb/test_latched_piso.sv
module test_latched_piso;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         sr_clr_n = 1'b1;
    logic         cap_strobe = 1'b0;
    logic         shift_strobe = 1'b0;
    logic         shift_mode = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int n_checks = 0;
    int n_fails  = 0;
    string phase = "R9";

    logic [W-1:0] m_lat = '0;
    logic [W-1:0] m_sr  = '0;
    bit cap_hist[$];
    bit sh_hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_piso #(.WIDTH(W)) i_latched_piso (
        .clk(clk), .por_n(por_n), .sr_clr_n(sr_clr_n),
        .cap_strobe(cap_strobe), .shift_strobe(shift_strobe),
        .shift_mode(shift_mode), .par_in(par_in), .ser_in(ser_in),
        .ser_out(ser_out)
    );

    task automatic model_edge();
        bit cp, sp;
        logic [W-1:0] nl;
        if (!por_n) begin
            cap_hist = '{0, 0, 0};
            sh_hist  = '{0, 0, 0};
            m_lat = '0;
            m_sr  = '0;
            return;
        end
        cp = cap_hist[cap_hist.size()-2] && !cap_hist[cap_hist.size()-3];
        sp = sh_hist[sh_hist.size()-2] && !sh_hist[sh_hist.size()-3];
        cap_hist.push_back(cap_strobe);
        sh_hist.push_back(shift_strobe);
        void'(cap_hist.pop_front());
        void'(sh_hist.pop_front());
        nl = cp ? par_in : m_lat;
        if (!sr_clr_n)       m_sr = '0;
        else if (!shift_mode) m_sr = nl;
        else if (sp)          m_sr = {m_sr[W-2:0], ser_in};
        m_lat = nl;
    endtask

    task automatic compare();
        n_checks++;
        if (ser_out !== m_sr[W-1]) begin
            n_fails++;
            $display("FAIL %s: ser_out actual %b expected %b at %0t",
                     phase, ser_out, m_sr[W-1], $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse_cap(input logic [W-1:0] v);
        par_in = v;
        cap_strobe = 1'b1;
        cycle();
        cap_strobe = 1'b0;
        cycles(4);
    endtask

    task automatic pulse_shift(input logic b);
        ser_in = b;
        shift_strobe = 1'b1;
        cycle();
        shift_strobe = 1'b0;
        cycles(3);
    endtask

    initial begin
        cap_hist = '{0, 0, 0};
        sh_hist  = '{0, 0, 0};
        // R9: reset state
        phase = "R9";
        cycles(3);
        por_n = 1'b1;
        cycles(2);

        // R1 R6: capture in load mode reaches the shift register
        phase = "R6";
        shift_mode = 1'b0;
        pulse_cap(8'hA5);
        phase = "R1";
        cycles(2);

        // R3 R4: shift a pattern through
        phase = "R3";
        shift_mode = 1'b1;
        for (int i = 0; i < W + 2; i++) pulse_shift(1'(i % 3 == 0));
        phase = "R4";
        for (int i = 0; i < W; i++) pulse_shift(1'(i & 1));

        // R8: idle in shift mode
        phase = "R8";
        par_in = 8'hFF;
        ser_in = 1'b1;
        cycles(10);

        // R10: held strobes act once
        phase = "R10";
        ser_in = 1'b1;
        shift_strobe = 1'b1;
        cycles(8);
        shift_strobe = 1'b0;
        cycles(3);
        par_in = 8'h81;
        cap_strobe = 1'b1;
        cycles(4);
        par_in = 8'h00;
        cycles(4);
        cap_strobe = 1'b0;
        cycles(3);

        // R1: capture in shift mode leaves sr alone, then reveal latch
        phase = "R1";
        pulse_cap(8'h3C);
        shift_mode = 1'b0;
        cycles(2);
        shift_mode = 1'b1;
        for (int i = 0; i < W; i++) pulse_shift(1'b0);

        // R5: asynchronous clear keeps latch
        phase = "R5";
        shift_mode = 1'b0;
        pulse_cap(8'hC3);
        shift_mode = 1'b1;
        #1;
        sr_clr_n = 1'b0;
        #1;
        m_sr = '0;
        compare();
        cycle();
        sr_clr_n = 1'b1;
        cycles(2);
        shift_mode = 1'b0;
        cycles(2);
        shift_mode = 1'b1;
        for (int i = 0; i < W; i++) pulse_shift(1'b1);

        // R2: serial input and shift strobe ignored in load mode
        phase = "R2";
        shift_mode = 1'b0;
        for (int i = 0; i < 6; i++) pulse_shift(1'(i & 1));

        // R7: both strobes together in shift mode
        phase = "R7";
        shift_mode = 1'b1;
        par_in = 8'h5A;
        ser_in = 1'b1;
        cap_strobe = 1'b1;
        shift_strobe = 1'b1;
        cycle();
        cap_strobe = 1'b0;
        shift_strobe = 1'b0;
        cycles(4);
        for (int i = 0; i < W; i++) pulse_shift(1'b0);
        shift_mode = 1'b0;
        cycles(2);
        shift_mode = 1'b1;
        for (int i = 0; i < W; i++) pulse_shift(1'b0);

        // mixed stimulus from an LFSR
        phase = "R3";
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cap_strobe   = lf[0] & lf[3];
                shift_strobe = lf[1];
                shift_mode   = lf[2] | lf[5];
                ser_in       = lf[4];
                par_in       = lf[15:8];
                sr_clr_n     = !(lf[6] & lf[7] & lf[9] & lf[11]);
                if (!sr_clr_n) begin
                    #1;
                    m_sr = '0;
                end
                cycle();
            end
        end
        sr_clr_n = 1'b1;
        cycles(4);

        // R9: power-on reset clears latch too
        phase = "R9";
        por_n = 1'b0;
        cycle();
        por_n = 1'b1;
        shift_mode = 1'b0;
        cycles(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not end, actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule